// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves a PLL to a new output frequency without letting an unsettled clock reach the rest of the chip. A single start pulse carries three requested ratios: pre-divider, multiplier and post-divider. The block then runs a fixed, timed sequence on the PLL control word and the ratio registers. It first bypasses the PLL output. It then places the PLL in reset, loads the encoded ratios and holds reset for a minimum time. It releases reset, waits for lock, and finally removes the bypass. Every wait is counted in cycles of the reference clock that also clocks the block.

The lock wait is worked out from the requested pre-divider. A square root of the multiplier enters that calculation and is approximated by a constant. When there is no pre-divider, a fixed 20 µs wait is used instead. Two elaboration parameters state whether the pre-divider and the post-divider exist. A missing divider is never written.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the control word `ctl_o` equals `CTL_RST`, which defaults to 0x138. `busy_o` and `done_o` are low, and all three ratio register outputs are zero.
- R2: A start accepted while idle raises `busy_o` at the next clock edge. At that same edge it clears control bits 0 (enable) and 5 (enable source), and every other control bit keeps its value.
- R3: The bypass state lasts `BYP_CYC` cycles (default 4). At the edge that ends it, bit 3 (reset release, 1 = released) and bit 4 (disable) are cleared.
- R4: The ratio registers are written one cycle after R3. A ratio register output changes only while control bits 0, 5 and 3 are all zero.
- R5: A divider ratio N ≠ 0 is stored as N−1 in the low bits, with bit 15 set as the divider-enable flag. A ratio of 0 stores 0x0000, which leaves the divider disabled.
- R6: A multiplier request M ≠ 0 is stored as M−1. A request of 0 stores 0, which means multiply-by-one.
- R7: Reset is held for ceil(125 ns × `REF_HZ`) cycles after the ratio write (7 cycles at 50 MHz). Bit 3 is then set.
- R8: After reset is released, the block waits L cycles and then sets bit 0. At that same edge `done_o` pulses for exactly one cycle and `busy_o` falls. L = 500 × P for a pre-divider request P ≠ 0, which is 2000 × P divided by an approximated square root of 4. For P = 0, L = `REF_HZ` / 50000, which is 20 µs.
- R9: A start seen while busy is ignored. It does not change the ratios written, the timing, or the state after completion, and it is not queued.
- R10: Control bits 1 (power-down) and 8 (clock mode) never change.
- R11: When `HAS_PREDIV` or `HAS_POSTDIV` is 0, the matching register output stays 0. When the pre-divider is absent, the lock wait is always the P = 0 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every wait is counted on it |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request; sampled only while idle |
| prediv_i | input | RW | Requested pre-divider ratio, 0 = disabled |
| mult_i | input | MW | Requested multiplier, 0 = multiply-by-one |
| postdiv_i | input | RW | Requested post-divider ratio, 0 = disabled |
| ctl_o | output | 9 | PLL control word |
| prediv_reg_o | output | 16 | Encoded pre-divider register |
| mult_reg_o | output | MW | Encoded multiplier register |
| postdiv_reg_o | output | 16 | Encoded post-divider register |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Take the edge that samples the start as k = 0. `busy_o` and the bypass bits then change at k = 0. The reset bits clear at k = `BYP_CYC`, and the ratio registers change at k = `BYP_CYC`+1. Reset is released at k = `BYP_CYC`+1+R. The done pulse, together with the enable bit, appears at k = `BYP_CYC`+1+R+L. The bench samples at every falling edge after the start. It records the first k at which each event appears and compares that k with the value computed from the formulas. It also checks that `done_o` is low again one sample later. For starts injected during a run, the bench compares the final register values with the first request and requires `busy_o` to stay low for a while after completion.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int CTL_W      = 9;
  localparam int CB_EN      = 0;
  localparam int CB_PD      = 1;
  localparam int CB_RST     = 3;
  localparam int CB_DIS     = 4;
  localparam int CB_SRC     = 5;
  localparam int CB_MODE    = 8;
  localparam int DIV_W      = 16;
  localparam int DIV_EN_BIT = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYP,
    ST_LOAD,
    ST_HOLD,
    ST_LOCK
  } seq_st_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pll_seq_enc.sv
module pll_seq_enc
  import pll_seq_pkg::*;
#(
  parameter int RW          = 5,
  parameter int MW          = 5,
  parameter bit HAS_PREDIV  = 1'b1,
  parameter bit HAS_POSTDIV = 1'b1,
  parameter int LOCK_PER    = 500,
  parameter int LOCK_NOPRE  = 500,
  parameter int CW          = 14
) (
  input  logic [RW-1:0]    pre_i,
  input  logic [MW-1:0]    mult_i,
  input  logic [RW-1:0]    post_i,
  output logic [DIV_W-1:0] pre_o,
  output logic [MW-1:0]    mult_o,
  output logic [DIV_W-1:0] post_o,
  output logic [CW-1:0]    lock_o
);
  // ratio N -> N-1 with enable flag; 0 -> divider off
  function automatic logic [DIV_W-1:0] enc_div(input logic [RW-1:0] r);
    logic [DIV_W-1:0] v;
    v = '0;
    if (r != '0) begin
      v[RW-1:0]       = r - 1'b1;
      v[DIV_EN_BIT]   = 1'b1;
    end
    return v;
  endfunction

  assign mult_o = (mult_i == '0) ? '0 : mult_i - 1'b1;

  generate
    if (HAS_PREDIV) begin : g_pre
      assign pre_o  = enc_div(pre_i);
      assign lock_o = (pre_i == '0) ? CW'(LOCK_NOPRE)
                                    : CW'(LOCK_PER) * CW'(pre_i);
    end else begin : g_nopre
      logic unused_pre;
      assign unused_pre = ^pre_i;
      assign pre_o      = '0;
      assign lock_o     = CW'(LOCK_NOPRE);
    end
    if (HAS_POSTDIV) begin : g_post
      assign post_o = enc_div(post_i);
    end else begin : g_nopost
      logic unused_post;
      assign unused_post = ^post_i;
      assign post_o      = '0;
    end
  endgenerate
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last_o = (cnt == CW'(1));

  // counter parks at zero instead of wrapping (R8 timing base)
  assert_timer_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load_i) |=> (cnt == '0));
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter logic [CTL_W-1:0] CTL_RST = 9'h138,
  parameter int CW      = 14,
  parameter int BYP_CYC = 4,
  parameter int RST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CW-1:0]    lock_cnt_i,
  input  logic             tmr_last_i,
  output logic             tmr_load_o,
  output logic [CW-1:0]    tmr_val_o,
  output logic             accept_o,
  output logic             wr_ratio_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_st_t st;

  always_comb begin
    accept_o   = start_i && (st == ST_IDLE);
    wr_ratio_o = (st == ST_LOAD);
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (accept_o) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = CW'(BYP_CYC);
    end else if (st == ST_LOAD) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = CW'(RST_CYC);
    end else if (st == ST_HOLD && tmr_last_i) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = lock_cnt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ctl_o  <= CTL_RST;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (accept_o) begin
          ctl_o[CB_EN]  <= 1'b0;
          ctl_o[CB_SRC] <= 1'b0;
          busy_o        <= 1'b1;
          st            <= ST_BYP;
        end
        ST_BYP: if (tmr_last_i) begin
          ctl_o[CB_RST] <= 1'b0;
          ctl_o[CB_DIS] <= 1'b0;
          st            <= ST_LOAD;
        end
        ST_LOAD: st <= ST_HOLD;
        ST_HOLD: if (tmr_last_i) begin
          ctl_o[CB_RST] <= 1'b1;
          st            <= ST_LOCK;
        end
        ST_LOCK: if (tmr_last_i) begin
          ctl_o[CB_EN] <= 1'b1;
          busy_o       <= 1'b0;
          done_o       <= 1'b1;
          st           <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_accept_bypasses_R2: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> (busy_o && !ctl_o[CB_EN] && !ctl_o[CB_SRC]));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_enable_only_at_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_o[CB_EN]) |-> (done_o && !busy_o));
  assert_keep_pd_mode_R10: assert property (@(posedge clk) disable iff (rst)
    $stable(ctl_o[CB_PD]) && $stable(ctl_o[CB_MODE]));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int REF_HZ      = 25_000_000,
  parameter int RW          = 5,
  parameter int MW          = 5,
  parameter bit HAS_PREDIV  = 1'b1,
  parameter bit HAS_POSTDIV = 1'b1,
  parameter int BYP_CYC     = 4,
  parameter int SQRT_APPROX = 4,
  parameter logic [8:0] CTL_RST = 9'h138
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [RW-1:0]     prediv_i,
  input  logic [MW-1:0]     mult_i,
  input  logic [RW-1:0]     postdiv_i,
  output logic [8:0]        ctl_o,
  output logic [15:0]       prediv_reg_o,
  output logic [MW-1:0]     mult_reg_o,
  output logic [15:0]       postdiv_reg_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int RST_CYC_RAW = int'((64'(REF_HZ) * 64'd125 + 64'd999_999_999)
                                    / 64'd1_000_000_000);
  localparam int RST_CYC    = (RST_CYC_RAW < 1) ? 1 : RST_CYC_RAW;
  localparam int LOCK_PER   = 2000 / SQRT_APPROX;
  localparam int LOCK_NOPRE = REF_HZ / 50_000;
  localparam int MAX_CNT    = max_of(max_of(LOCK_PER * ((1 << RW) - 1), LOCK_NOPRE),
                                     max_of(RST_CYC, BYP_CYC));
  localparam int CW         = $clog2(MAX_CNT + 1);

  logic [DIV_W-1:0] pre_enc, post_enc, pre_q, post_q;
  logic [MW-1:0]    mult_enc, mult_q;
  logic [CW-1:0]    lock_enc, lock_q, tmr_val;
  logic             tmr_load, tmr_last, accept, wr_ratio;

  pll_seq_enc #(
    .RW(RW), .MW(MW), .HAS_PREDIV(HAS_PREDIV), .HAS_POSTDIV(HAS_POSTDIV),
    .LOCK_PER(LOCK_PER), .LOCK_NOPRE(LOCK_NOPRE), .CW(CW)
  ) u_enc (
    .pre_i(prediv_i), .mult_i(mult_i), .post_i(postdiv_i),
    .pre_o(pre_enc), .mult_o(mult_enc), .post_o(post_enc), .lock_o(lock_enc)
  );

  pll_seq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .val_i(tmr_val), .last_o(tmr_last)
  );

  pll_seq_ctrl #(
    .CTL_RST(CTL_RST), .CW(CW), .BYP_CYC(BYP_CYC), .RST_CYC(RST_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .lock_cnt_i(lock_q),
    .tmr_last_i(tmr_last), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .accept_o(accept), .wr_ratio_o(wr_ratio), .ctl_o(ctl_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // request capture at accepted start
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      mult_q <= '0;
      post_q <= '0;
      lock_q <= '0;
    end else if (accept) begin
      pre_q  <= pre_enc;
      mult_q <= mult_enc;
      post_q <= post_enc;
      lock_q <= lock_enc;
    end
  end

  // PLL ratio registers
  always_ff @(posedge clk) begin
    if (rst) begin
      prediv_reg_o  <= '0;
      mult_reg_o    <= '0;
      postdiv_reg_o <= '0;
    end else if (wr_ratio) begin
      prediv_reg_o  <= pre_q;
      mult_reg_o    <= mult_q;
      postdiv_reg_o <= post_q;
    end
  end

  assert_ratio_write_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(prediv_reg_o) || !$stable(mult_reg_o) || !$stable(postdiv_reg_o))
      |-> (!ctl_o[CB_EN] && !ctl_o[CB_SRC] && !ctl_o[CB_RST]));
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(lock_q) && $stable(pre_q) && $stable(mult_q)));
endmodule

// File: tb/test_pll_reprog_seq.sv
`timescale 1ns/1ps
module test_pll_reprog_seq;
  localparam int RW = 5;
  localparam int MW = 5;
  localparam int REF = 50_000_000;
  localparam int NB  = 4;
  localparam int RH  = 7;     // ceil(125 ns * 50 MHz)
  localparam int LNP = 1000;  // 20 us at 50 MHz

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, start_b = 1'b0;
  logic [RW-1:0] prediv_i = '0, postdiv_i = '0;
  logic [MW-1:0] mult_i = '0;
  logic [8:0]  ctl_o, ctl_b;
  logic [15:0] prediv_reg_o, postdiv_reg_o, pre_b, post_b;
  logic [MW-1:0] mult_reg_o, mult_b;
  logic busy_o, done_o, busy_b, done_b;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pll_reprog_seq #(.REF_HZ(REF), .RW(RW), .MW(MW)) i_pll_reprog_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .prediv_i(prediv_i),
    .mult_i(mult_i), .postdiv_i(postdiv_i), .ctl_o(ctl_o),
    .prediv_reg_o(prediv_reg_o), .mult_reg_o(mult_reg_o),
    .postdiv_reg_o(postdiv_reg_o), .busy_o(busy_o), .done_o(done_o)
  );

  pll_reprog_seq #(.REF_HZ(REF), .RW(RW), .MW(MW),
                   .HAS_PREDIV(1'b0), .HAS_POSTDIV(1'b0)) i_pll_reprog_seq_nodiv (
    .clk(clk), .rst(rst), .start_i(start_b), .prediv_i(prediv_i),
    .mult_i(mult_i), .postdiv_i(postdiv_i), .ctl_o(ctl_b),
    .prediv_reg_o(pre_b), .mult_reg_o(mult_b),
    .postdiv_reg_o(post_b), .busy_o(busy_b), .done_o(done_b)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] div_code(input int n);
    return (n == 0) ? 16'h0000 : (16'h8000 | 16'(n - 1));
  endfunction

  task automatic test_reset();
    chk(ctl_o == 9'h138, "R1 ctl", ctl_o, 9'h138);
    chk(!busy_o && !done_o, "R1 busy/done", {busy_o, done_o}, 0);
    chk(prediv_reg_o == 0 && mult_reg_o == 0 && postdiv_reg_o == 0,
        "R1 ratio regs", {prediv_reg_o, mult_reg_o, postdiv_reg_o}, 0);
  endtask

  task automatic run_seq(input int p, input int m, input int q, input bit poke);
    int lk, k_rst, k_load, k_rel, k_done;
    logic [15:0] pre0;
    logic [8:0]  ctl0;
    bit gate_ok, pdm_ok, en_at_done, busy_at_done;
    lk = (p == 0) ? LNP : 500 * p;
    k_rst = -1; k_load = -1; k_rel = -1; k_done = -1;
    gate_ok = 1'b1; pdm_ok = 1'b1; en_at_done = 1'b0; busy_at_done = 1'b1;
    pre0 = prediv_reg_o;
    ctl0 = ctl_o;
    prediv_i = RW'(p); mult_i = MW'(m); postdiv_i = RW'(q);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R2 busy", busy_o, 1);
    chk(ctl_o == (ctl0 & ~9'h021), "R2 bypass bits", ctl_o, ctl0 & ~9'h021);
    for (int k = 0; k < lk + 60 && k_done < 0; k++) begin
      if (k_rst < 0 && !ctl_o[3]) k_rst = k;
      if (k_load < 0 && prediv_reg_o != pre0) begin
        k_load = k;
        gate_ok = !ctl_o[0] && !ctl_o[5] && !ctl_o[3];
      end
      if (k_rst >= 0 && k_rel < 0 && ctl_o[3]) k_rel = k;
      if (k_done < 0 && done_o) begin
        k_done = k; en_at_done = ctl_o[0]; busy_at_done = busy_o;
      end
      if (ctl_o[1] != ctl0[1] || ctl_o[8] != ctl0[8]) pdm_ok = 1'b0;
      start_i = poke && (k == 2 || k == NB + 3);
      if (start_i) begin
        prediv_i = RW'(p + 2); mult_i = MW'(m + 3); postdiv_i = RW'(q + 1);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(k_rst == NB, "R3 bypass length", k_rst, NB);
    chk(k_load == NB + 1, "R4 ratio write cycle", k_load, NB + 1);
    chk(gate_ok, "R4 write while bypassed+reset", gate_ok, 1);
    chk(prediv_reg_o == div_code(p), "R5 prediv code", prediv_reg_o, div_code(p));
    chk(postdiv_reg_o == div_code(q), "R5 postdiv code", postdiv_reg_o, div_code(q));
    chk(mult_reg_o == ((m == 0) ? 0 : MW'(m - 1)), "R6 mult code", mult_reg_o,
        (m == 0) ? 0 : m - 1);
    chk(k_rel == NB + 1 + RH, "R7 reset hold", k_rel, NB + 1 + RH);
    chk(k_done == NB + 1 + RH + lk, "R8 lock wait", k_done, NB + 1 + RH + lk);
    chk(en_at_done && !busy_at_done, "R8 enable/busy at done",
        {en_at_done, busy_at_done}, 2);
    chk(!done_o, "R8 done one cycle", done_o, 0);
    chk(pdm_ok, "R10 power-down/clock-mode kept", pdm_ok, 1);
    if (poke) begin
      for (int i = 0; i < 20; i++) begin
        if (busy_o) begin
          chk(1'b0, "R9 start while busy queued", busy_o, 0);
          break;
        end
        @(negedge clk);
      end
      chk(!busy_o, "R9 idle after ignored starts", busy_o, 0);
    end
  endtask

  task automatic run_nodiv(input int p, input int m, input int q);
    int k_done;
    k_done = -1;
    prediv_i = RW'(p); mult_i = MW'(m); postdiv_i = RW'(q);
    start_b = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_b = 1'b0;
    for (int k = 0; k < LNP + 60 && k_done < 0; k++) begin
      if (done_b) k_done = k;
      @(negedge clk);
    end
    chk(pre_b == 0 && post_b == 0, "R11 absent dividers zero", {pre_b, post_b}, 0);
    chk(mult_b == MW'(m - 1), "R11 mult still written", mult_b, m - 1);
    chk(k_done == NB + 1 + RH + LNP, "R11 lock uses fixed wait", k_done,
        NB + 1 + RH + LNP);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_seq(3, 20, 2, 1'b0);
    run_seq(0, 0, 0, 1'b0);
    run_seq(1, 1, 31, 1'b1);
    run_seq(31, 31, 0, 1'b0);
    run_nodiv(5, 7, 3);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule